// File: doc/BRIEF.md
# Dual GPIO Pin Controller with Timer Alternate Function

This block configures and controls a small group of general-purpose pins (two by default) that share their pads with a timer's capture inputs and interval-pulse outputs. Each pin owns an 8-bit configuration register on a simple register bus. Those registers live at consecutive addresses starting at 0x0A: pin 0 at 0x0A and pin 1 at 0x0B. The block also takes each pin's bit of the port data register, which is held outside the block.

For every pin the block works out the pad's output value, output enable and pull-up enable, and applies open-drain drive when that is selected. It also picks the value sent to the timer's capture input: the pad level when the pin is an input, or the firmware data bit when the pin is a plain output. This lets software stimulate the capture logic. In timer-output mode the pad carries the timer's interval pulse. That pulse is never gated by the pin's interrupt enable. Each pin also raises a level-sensitive interrupt request with selectable polarity, taken from a synchronized copy of the pad level.

Configuration bit positions:
- bit 7: timer-output select
- bit 6: interrupt enable
- bit 5: interrupt active-low
- bit 4: threshold select (storage only)
- bit 3: reserved
- bit 2: open-drain
- bit 1: pull-up enable
- bit 0: output enable

Top module: `gpio_tmr_pinctl`

## Requirements
- R1: After reset every configuration register reads 0x00, and pad_oe, pad_pu and pin_irq are all 0.
- R2: A write with bus_we high at address 0x0A+i updates pin i's register, and reads at that address return it. Reads at any other address return 0x00, and writes there change no register.
- R3: Bit 3 of every register reads 0 whatever value was written to it. All other bits read back as written.
- R4: With output enable (bit 0) clear, pad_oe is 0 and tmr_cap follows pad_in.
- R5: With output enable set and timer-output select (bit 7) clear, the driven value is port_data. Both pad_out (push-pull) and tmr_cap follow port_data, whatever pad_in is doing.
- R6: With output enable and timer-output select both set, the driven value is tmr_pulse and port_data has no effect on it. This holds even while interrupt enable (bit 6) is 0.
- R7: With open-drain (bit 2) set, pad_out is 0. pad_oe is 1 only while output enable is set and the driven value is 0, so the pin never drives high.
- R8: pad_pu equals the pull-up bit (bit 1), except that it is 0 while the pin drives high in push-pull mode.
- R9: pin_irq equals interrupt enable AND (synchronized pad level XOR active-low bit 5). A pad change reaches pin_irq on the second rising clock edge after it. A change in the enable or polarity bits takes effect at once.
- R10: The interrupt controls behave the same way in timer-output mode as in GPIO mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Register bus address |
| bus_wdata | input | 8 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| port_data | input | NUM_PINS | Pin bits of the port data register |
| tmr_pulse | input | NUM_PINS | Timer interval pulses (bit 0 fixed interval, bit 1 programmable) |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| pad_pu | output | NUM_PINS | Pad pull-up enables |
| tmr_cap | output | NUM_PINS | Timer capture inputs |
| pin_irq | output | NUM_PINS | Level interrupt requests |

## Verification
The only internal state is each pin's configuration register and its synchronizer chain. A wrong register value shows up at once on bus_rdata and on the pad, capture and pull-up outputs, because all of those are combinational from the register. A fault in the synchronizer shows up on pin_irq: it either changes on the first edge after a pad change, or misses the second edge. The bench therefore samples pin_irq both between the two edges and after the second one. Open-drain and pull-up faults are visible at the same moment the driven value changes.

// File: rtl/gpio_tmr_pkg.sv
package gpio_tmr_pkg;
   typedef struct packed {
      logic tmr_out;
      logic irq_en;
      logic irq_low;
      logic ttl_sel;
      logic rsvd;
      logic od;
      logic pu;
      logic oe;
   } pin_cfg_t;

   localparam int        CFG_W     = 8;
   localparam logic [7:0] CFG_WMASK = 8'hF7;
endpackage

// File: rtl/gpio_cfg_reg.sv
module gpio_cfg_reg
   import gpio_tmr_pkg::*;
#(
   parameter int                ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] MY_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CFG_W-1:0]  wdata,
   output pin_cfg_t          cfg_o,
   output logic              hit_o
);
   pin_cfg_t cfg_q;

   assign hit_o = (addr == MY_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we && hit_o) begin
         cfg_q <= pin_cfg_t'(wdata & CFG_WMASK);
      end
   end

   assign cfg_o = cfg_q;

   // R3: reserved bit never holds a one
   p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.rsvd == 1'b0);

   // R2: a write to another address leaves the register alone
   p_miss_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_o) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
   import gpio_tmr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pin_cfg_t cfg,
   input  logic     port_bit,
   input  logic     tmr_bit,
   input  logic     pad_in,
   output logic     pad_out,
   output logic     pad_oe,
   output logic     pad_pu,
   output logic     tmr_cap
);
   logic drive_val;
   logic push_high;

   assign drive_val = cfg.tmr_out ? tmr_bit : port_bit;

   always_comb begin
      if (cfg.od) begin
         pad_out = 1'b0;
         pad_oe  = cfg.oe & ~drive_val;
      end else begin
         pad_out = drive_val;
         pad_oe  = cfg.oe;
      end
   end

   assign push_high = cfg.oe & ~cfg.od & drive_val;
   assign pad_pu    = cfg.pu & ~push_high;
   assign tmr_cap   = (cfg.oe && !cfg.tmr_out) ? port_bit : pad_in;

   // R7: an open-drain pin is never driven high
   p_od_no_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe && pad_out) |-> !cfg.od);

   // R8: pull-up never fights an active high drive
   p_pu_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_oe && pad_out) |-> !pad_pu);

   // R6: timer routing ignores the interrupt enable
   p_tmr_route_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.oe && cfg.tmr_out && !cfg.od) |-> (pad_out == tmr_bit));

   // R4: input pins never drive
   p_in_no_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg.oe) |-> (!pad_oe && tmr_cap == pad_in));
endmodule

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pad_in,
   input  logic irq_en,
   input  logic irq_low,
   output logic irq_o
);
   logic [STAGES-1:0] sync_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pad_in};
      end
   end

   assign irq_o = irq_en & (sync_q[STAGES-1] ^ irq_low);

   // R9: no request while disabled
   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en) |-> !irq_o);
endmodule

// File: rtl/gpio_tmr_pinctl.sv
module gpio_tmr_pinctl
   import gpio_tmr_pkg::*;
#(
   parameter int                NUM_PINS    = 2,
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h0A,
   parameter int                SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [CFG_W-1:0]    bus_wdata,
   input  logic                bus_we,
   output logic [CFG_W-1:0]    bus_rdata,
   input  logic [NUM_PINS-1:0] port_data,
   input  logic [NUM_PINS-1:0] tmr_pulse,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_pu,
   output logic [NUM_PINS-1:0] tmr_cap,
   output logic [NUM_PINS-1:0] pin_irq
);
   localparam int TOP_ADDR = int'(BASE_ADDR) + NUM_PINS;

   generate
      if (NUM_PINS < 1) begin : g_bad_n
         $error("gpio_tmr_pinctl: NUM_PINS must be at least 1");
      end
      if (TOP_ADDR > (1 << ADDR_W)) begin : g_bad_a
         $error("gpio_tmr_pinctl: register window exceeds address space");
      end
   endgenerate

   pin_cfg_t            cfg_q [NUM_PINS];
   logic [NUM_PINS-1:0] hit;

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_cfg_reg #(
         .ADDR_W (ADDR_W),
         .MY_ADDR(ADDR_W'(int'(BASE_ADDR) + i))
      ) u_cfg (
         .clk  (clk),
         .rst_n(rst_n),
         .we   (bus_we),
         .addr (bus_addr),
         .wdata(bus_wdata),
         .cfg_o(cfg_q[i]),
         .hit_o(hit[i])
      );

      gpio_pin_mux u_mux (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg_q[i]),
         .port_bit(port_data[i]),
         .tmr_bit (tmr_pulse[i]),
         .pad_in  (pad_in[i]),
         .pad_out (pad_out[i]),
         .pad_oe  (pad_oe[i]),
         .pad_pu  (pad_pu[i]),
         .tmr_cap (tmr_cap[i])
      );

      gpio_irq_sync #(.STAGES(SYNC_STAGES)) u_irq (
         .clk    (clk),
         .rst_n  (rst_n),
         .pad_in (pad_in[i]),
         .irq_en (cfg_q[i].irq_en),
         .irq_low(cfg_q[i].irq_low),
         .irq_o  (pin_irq[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (hit[i]) bus_rdata = cfg_q[i];
      end
   end

   // R2: unmapped reads return zero
   p_rd_unmapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (bus_rdata == '0));

   // R3: read data never shows the reserved bit
   p_rd_rsvd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[3] == 1'b0);
endmodule

// File: tb/gpio_tmr_pinctl_tb.sv
module gpio_tmr_pinctl_tb;
   localparam int N = 2;

   logic       clk = 0;
   logic       rst_n = 0;
   logic [7:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0;
   logic       bus_we = 0;
   logic [7:0] bus_rdata;
   logic [N-1:0] port_data = 0, tmr_pulse = 0, pad_in = 0;
   logic [N-1:0] pad_out, pad_oe, pad_pu, tmr_cap, pin_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   gpio_tmr_pinctl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_rdata(bus_rdata), .port_data(port_data),
      .tmr_pulse(tmr_pulse), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pu(pad_pu), .tmr_cap(tmr_cap), .pin_irq(pin_irq)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1;
      @(negedge clk);
      bus_we = 0;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1 chk(req, bus_rdata, exp);
   endtask

   task automatic settle;
      @(negedge clk);
      #1;
   endtask

   task automatic t_reset;
      rd_chk("R1 reg0", 8'h0A, 8'h00);
      rd_chk("R1 reg1", 8'h0B, 8'h00);
      chk("R1 oe", {6'b0, pad_oe}, 8'h00);
      chk("R1 pu", {6'b0, pad_pu}, 8'h00);
      chk("R1 irq", {6'b0, pin_irq}, 8'h00);
   endtask

   task automatic t_regs;
      wr(8'h0A, 8'hFF);
      rd_chk("R3 reg0 rsvd", 8'h0A, 8'hF7);
      wr(8'h0B, 8'h5A);
      rd_chk("R3 reg1 rsvd", 8'h0B, 8'h52);
      wr(8'h0C, 8'hFF);
      rd_chk("R2 unmapped read", 8'h0C, 8'h00);
      rd_chk("R2 reg0 untouched", 8'h0A, 8'hF7);
      rd_chk("R2 reg1 untouched", 8'h0B, 8'h52);
      wr(8'h0A, 8'h00);
      wr(8'h0B, 8'h00);
      rd_chk("R2 reg0 cleared", 8'h0A, 8'h00);
   endtask

   task automatic t_input;
      wr(8'h0A, 8'h00);
      port_data = 2'b01; pad_in = 2'b01;
      settle();
      chk("R4 oe off", {7'b0, pad_oe[0]}, 8'h00);
      chk("R4 cap high", {7'b0, tmr_cap[0]}, 8'h01);
      pad_in = 2'b00;
      settle();
      chk("R4 cap low", {7'b0, tmr_cap[0]}, 8'h00);
   endtask

   task automatic t_gpio;
      wr(8'h0A, 8'h01);
      port_data = 2'b01; pad_in = 2'b00;
      settle();
      chk("R5 oe", {7'b0, pad_oe[0]}, 8'h01);
      chk("R5 out high", {7'b0, pad_out[0]}, 8'h01);
      chk("R5 cap from data", {7'b0, tmr_cap[0]}, 8'h01);
      port_data = 2'b00; pad_in = 2'b01;
      settle();
      chk("R5 out low", {7'b0, pad_out[0]}, 8'h00);
      chk("R5 cap low", {7'b0, tmr_cap[0]}, 8'h00);
   endtask

   task automatic t_tmr;
      wr(8'h0B, 8'h81);
      port_data = 2'b00; tmr_pulse = 2'b10;
      settle();
      chk("R6 pulse high", {7'b0, pad_out[1]}, 8'h01);
      chk("R6 oe", {7'b0, pad_oe[1]}, 8'h01);
      port_data = 2'b10; tmr_pulse = 2'b00;
      settle();
      chk("R6 data ignored", {7'b0, pad_out[1]}, 8'h00);
      wr(8'h0B, 8'h00);
   endtask

   task automatic t_od;
      wr(8'h0A, 8'h05);
      port_data = 2'b01;
      settle();
      chk("R7 release high", {7'b0, pad_oe[0]}, 8'h00);
      chk("R7 out zero", {7'b0, pad_out[0]}, 8'h00);
      port_data = 2'b00;
      settle();
      chk("R7 drive low", {7'b0, pad_oe[0]}, 8'h01);
      chk("R7 out low", {7'b0, pad_out[0]}, 8'h00);
   endtask

   task automatic t_pu;
      wr(8'h0A, 8'h03);
      port_data = 2'b01;
      settle();
      chk("R8 pu off on high drive", {7'b0, pad_pu[0]}, 8'h00);
      port_data = 2'b00;
      settle();
      chk("R8 pu on low drive", {7'b0, pad_pu[0]}, 8'h01);
      wr(8'h0A, 8'h07);
      port_data = 2'b01;
      settle();
      chk("R8 pu on open drain", {7'b0, pad_pu[0]}, 8'h01);
      wr(8'h0A, 8'h02);
      settle();
      chk("R8 pu on input", {7'b0, pad_pu[0]}, 8'h01);
   endtask

   task automatic t_irq;
      wr(8'h0A, 8'h40);
      @(negedge clk); pad_in = 2'b00;
      repeat (3) @(negedge clk);
      pad_in = 2'b01;
      @(negedge clk); #1;
      chk("R9 not yet after one edge", {7'b0, pin_irq[0]}, 8'h00);
      @(negedge clk); #1;
      chk("R9 raised after two edges", {7'b0, pin_irq[0]}, 8'h01);
      wr(8'h0A, 8'h60);
      #1 chk("R9 active low idle", {7'b0, pin_irq[0]}, 8'h00);
      pad_in = 2'b00;
      @(negedge clk); #1;
      chk("R9 low not yet", {7'b0, pin_irq[0]}, 8'h00);
      @(negedge clk); #1;
      chk("R9 low raised", {7'b0, pin_irq[0]}, 8'h01);
      wr(8'h0A, 8'hE1);
      tmr_pulse = 2'b00;
      #1 chk("R10 irq in timer mode", {7'b0, pin_irq[0]}, 8'h01);
      wr(8'h0A, 8'hA1);
      #1 chk("R10 disabled in timer mode", {7'b0, pin_irq[0]}, 8'h00);
      wr(8'h0A, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_regs();
      t_input();
      t_gpio();
      t_tmr();
      t_od();
      t_pu();
      t_irq();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule